// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers the interrupt sources of a small 8-bit controller and presents the most urgent one to the core, together with the 12-bit address of its vector pair. The sources are a reset request, a non-maskable interrupt line, two external port lines (the "A" line and a shared "B/C" line), a timer zero flag and an end-of-conversion flag. The option byte is written by the core as a whole byte at one fixed address. It sets the detection mode of each port line and a global enable for the maskable sources.

The selected request leaves the block on a valid/ready pair. `irq_valid_o` is high while any unmasked request exists, and `irq_vector_o` and `irq_grant_o` name the winner. The core takes the request by raising `irq_ready_i`; the transfer happens on a clock edge where both are high. There is no hold rule on the payload. While valid waits for ready, a request of higher priority can displace the one shown, and the displaced request stays pending. A latched edge request is cleared only by a transfer naming it. Level requests (reset, port A in level mode, timer, conversion) follow their inputs and ignore transfers. A separate `wake_o` tells a sleeping core to resume.

The external lines pass through a two-stage synchronizer, so an edge becomes visible three clock edges after the pin changes. A low level becomes visible two clock edges after the pin changes.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the option byte is 00h. The maskable sources are then masked: with only the timer flag high, `irq_valid_o`=0, `wake_o`=0 and `irq_vector_o`=000h.
- R2: A write updates the option byte only when the address equals C8h. Bit 6 selects the port A mode (0 falling edge, 1 low level), bit 5 selects the B/C edge (0 falling, 1 rising) and bit 4 is the global enable. A write to any other address has no effect.
- R3: Priority and vectors, from highest to lowest: reset FFEh, NMI FFCh, port A FF8h, port B/C FF6h, timer FF4h, conversion FF2h. FFAh and FF0h are never produced. When no request exists the vector reads 000h.
- R4: With the global enable at 0, the port A, port B/C, timer and conversion requests are not presented, while reset and NMI still are.
- R5: A falling edge on `nmi_n_i` latches an NMI request, which stays pending until a transfer whose vector is FFCh.
- R6: In falling-edge mode a port A falling edge is latched until a transfer of FF8h. In low-level mode the request follows the low pin, is not cleared by a transfer, and ends when the pin returns high.
- R7: Port B/C latches only edges of the selected direction; an edge of the other direction raises no request. The latched request clears on a transfer of FF6h.
- R8: The timer and conversion requests follow their flags and are not cleared by a transfer.
- R9: `wake_o` is high when a reset request exists, or when the global enable is 1 and an NMI, port A, port B/C or timer request exists. The conversion request never wakes, and NMI does not wake while the enable is 0.
- R10: When a new edge on a port line is detected in the same cycle as the transfer that clears that line's latched request, the request stays pending.
- R11: `irq_grant_o` is one-hot for the winner (bit index 0 reset, 1 NMI, 3 port A, 4 port B/C, 5 timer, 6 conversion) or zero, and `irq_valid_o` equals its OR.
- R12: A write to C8h whose bits 7 or 3:0 are not all zero is ignored as a whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en_i | input | 1 | Option byte write strobe |
| cfg_wr_addr_i | input | 8 | Write address |
| cfg_wr_data_i | input | 8 | Write data |
| rst_req_i | input | 1 | Reset request, level, synchronous |
| nmi_n_i | input | 1 | Non-maskable interrupt pin, falling edge |
| pa_n_i | input | 1 | Port A interrupt pin |
| pbc_i | input | 1 | Port B/C interrupt pin |
| tmz_i | input | 1 | Timer zero flag, level |
| eoc_i | input | 1 | End-of-conversion flag, level |
| irq_valid_o | output | 1 | A request is presented |
| irq_ready_i | input | 1 | Core accepts the presented request |
| irq_vector_o | output | 12 | Vector address of the winner |
| irq_grant_o | output | 8 | One-hot winner by source index |
| wake_o | output | 1 | Leave STOP or WAIT |

## Verification
A transfer that clears a latched port request and the detection of a fresh edge on the same line can fall in the same clock cycle. The bench provokes this by driving a second falling edge on the B/C line, counting two clock edges, and then raising ready so that the transfer edge is the very edge where the detector sets the pending bit. The request must still be presented afterwards, and a second transfer with no new edge must then clear it. Randomized pin, write and accept sequences also let reset requests coincide with pending NMI transfers, and these are judged against the bench's priority model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC   = 8;
  localparam int IDX_W  = $clog2(NSRC);
  localparam int VEC_W  = 12;
  localparam logic [VEC_W-1:0] VEC_TOP = 12'hFFE;

  typedef enum logic [IDX_W-1:0] {
    SRC_RESET  = 3'd0,
    SRC_NMI    = 3'd1,
    SRC_SPAREH = 3'd2,
    SRC_PORTA  = 3'd3,
    SRC_PORTBC = 3'd4,
    SRC_TIMER  = 3'd5,
    SRC_ADC    = 3'd6,
    SRC_SPAREL = 3'd7
  } src_e;

  // sources gated by the global enable
  localparam logic [NSRC-1:0] MASKABLE = (NSRC'(1) << SRC_PORTA) | (NSRC'(1) << SRC_PORTBC)
                                       | (NSRC'(1) << SRC_TIMER) | (NSRC'(1) << SRC_ADC);
  // sources able to wake the core
  localparam logic [NSRC-1:0] WAKEABLE = (NSRC'(1) << SRC_RESET) | (NSRC'(1) << SRC_NMI)
                                       | (NSRC'(1) << SRC_PORTA) | (NSRC'(1) << SRC_PORTBC)
                                       | (NSRC'(1) << SRC_TIMER);
  // sources that wake even when the global enable is clear
  localparam logic [NSRC-1:0] WAKE_NOGEN = (NSRC'(1) << SRC_RESET);

  typedef struct packed {
    logic lvl_a;    // port A low-level mode
    logic rise_bc;  // port B/C rising edge
    logic gen;      // global enable
  } opt_t;

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    return VEC_TOP - {{(VEC_W-IDX_W-1){1'b0}}, idx, 1'b0};
  endfunction
endpackage

// File: rtl/irq_opt_reg.sv
module irq_opt_reg
  import irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] OPT_ADDR = 8'hC8,
  parameter int BIT_LVL  = 6,
  parameter int BIT_RISE = 5,
  parameter int BIT_GEN  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output opt_t              opt_o
);
  localparam logic [DATA_W-1:0] USED = (DATA_W'(1) << BIT_LVL) | (DATA_W'(1) << BIT_RISE)
                                     | (DATA_W'(1) << BIT_GEN);
  localparam logic [DATA_W-1:0] RSVD = ~USED;

  logic take;
  assign take = wr_en_i && (wr_addr_i == OPT_ADDR) && ((wr_data_i & RSVD) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_o <= '0;
    end else if (take) begin
      opt_o.lvl_a   <= wr_data_i[BIT_LVL];
      opt_o.rise_bc <= wr_data_i[BIT_RISE];
      opt_o.gen     <= wr_data_i[BIT_GEN];
    end
  end
endmodule

// File: rtl/irq_pin_detect.sv
module irq_pin_detect #(
  parameter int   SYNC_STAGES = 2,
  parameter logic IDLE_LEVEL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic rise_sel_i,
  input  logic level_mode_i,
  input  logic clr_i,
  output logic req_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q;
  logic pend_q;
  logic sample;
  logic edge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
      prev_q <= IDLE_LEVEL;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sample;
    end
  end

  assign sample   = sync_q[SYNC_STAGES-1];
  assign edge_hit = rise_sel_i ? (sample & ~prev_q) : (~sample & prev_q);

  // a new edge outranks a clearing transfer in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pend_q <= 1'b0;
    else if (level_mode_i) pend_q <= 1'b0;
    else if (edge_hit)     pend_q <= 1'b1;
    else if (clr_i)        pend_q <= 1'b0;
  end

  assign req_o = level_mode_i ? ~sample : pend_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o   = |req_i;
  assign grant_o = any_o ? (N'(1) << idx_o) : '0;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] OPT_ADDR = 8'hC8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en_i,
  input  logic [ADDR_W-1:0] cfg_wr_addr_i,
  input  logic [DATA_W-1:0] cfg_wr_data_i,
  input  logic              rst_req_i,
  input  logic              nmi_n_i,
  input  logic              pa_n_i,
  input  logic              pbc_i,
  input  logic              tmz_i,
  input  logic              eoc_i,
  output logic              irq_valid_o,
  input  logic              irq_ready_i,
  output logic [VEC_W-1:0]  irq_vector_o,
  output logic [NSRC-1:0]   irq_grant_o,
  output logic              wake_o
);
  opt_t             opt_q;
  logic             gen_en;
  logic [NSRC-1:0]  req_raw;
  logic [NSRC-1:0]  req_eff;
  logic [NSRC-1:0]  wake_bits;
  logic [IDX_W-1:0] win_idx;
  logic             accept;
  logic             nmi_req, pa_req, pbc_req;

  irq_opt_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OPT_ADDR(OPT_ADDR)
  ) opt_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(cfg_wr_en_i),
    .wr_addr_i(cfg_wr_addr_i), .wr_data_i(cfg_wr_data_i), .opt_o(opt_q)
  );

  assign gen_en = opt_q.gen;
  assign accept = irq_valid_o && irq_ready_i;

  irq_pin_detect #(.SYNC_STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) nmi_det_i (
    .clk(clk), .rst_n(rst_n), .pin_i(nmi_n_i), .rise_sel_i(1'b0),
    .level_mode_i(1'b0), .clr_i(accept && irq_grant_o[SRC_NMI]), .req_o(nmi_req)
  );

  irq_pin_detect #(.SYNC_STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) pa_det_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pa_n_i), .rise_sel_i(1'b0),
    .level_mode_i(opt_q.lvl_a), .clr_i(accept && irq_grant_o[SRC_PORTA]), .req_o(pa_req)
  );

  irq_pin_detect #(.SYNC_STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) pbc_det_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pbc_i), .rise_sel_i(opt_q.rise_bc),
    .level_mode_i(1'b0), .clr_i(accept && irq_grant_o[SRC_PORTBC]), .req_o(pbc_req)
  );

  always_comb begin
    req_raw             = '0;
    req_raw[SRC_RESET]  = rst_req_i;
    req_raw[SRC_NMI]    = nmi_req;
    req_raw[SRC_PORTA]  = pa_req;
    req_raw[SRC_PORTBC] = pbc_req;
    req_raw[SRC_TIMER]  = tmz_i;
    req_raw[SRC_ADC]    = eoc_i;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign req_eff[g]   = req_raw[g] && (!MASKABLE[g] || gen_en);
    assign wake_bits[g] = req_eff[g] && WAKEABLE[g] && (gen_en || WAKE_NOGEN[g]);
  end

  irq_prio_enc #(.N(NSRC), .IDX_W(IDX_W)) prio_i (
    .req_i(req_eff), .grant_o(irq_grant_o), .idx_o(win_idx), .any_o(irq_valid_o)
  );

  assign irq_vector_o = irq_valid_o ? vec_of(win_idx) : '0;
  assign wake_o       = |wake_bits;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rst_req_i,
  input logic        irq_valid_o,
  input logic        irq_ready_i,
  input logic [11:0] irq_vector_o,
  input logic [7:0]  irq_grant_o,
  input logic        wake_o,
  input logic        gen
);
  p_grant_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_grant_o) && (irq_valid_o == (irq_grant_o != 8'h00)));

  p_reset_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_i |-> (irq_valid_o && irq_vector_o == 12'hFFE && irq_grant_o[0]));

  p_mask_gen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !gen |-> (irq_grant_o[6:3] == 4'b0000));

  p_nmi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_grant_o[1] && !irq_ready_i) |=> (irq_grant_o[1] || rst_req_i));

  p_adc_no_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (irq_valid_o && !irq_grant_o[6]));

  p_gen_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen && !rst_req_i) |-> !wake_o);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req_i), .irq_valid_o(irq_valid_o),
  .irq_ready_i(irq_ready_i), .irq_vector_o(irq_vector_o), .irq_grant_o(irq_grant_o),
  .wake_o(wake_o), .gen(gen_en)
);

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;
  localparam int CLK_PERIOD_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_wr_addr = '0;
  logic [7:0]  cfg_wr_data = '0;
  logic        rst_req = 1'b0, nmi_n = 1'b1, pa_n = 1'b1, pbc = 1'b1, tmz = 1'b0, eoc = 1'b0;
  logic        irq_valid, irq_ready = 1'b0, wake;
  logic [11:0] irq_vector;
  logic [7:0]  irq_grant;

  irq_vector_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en_i(cfg_wr_en), .cfg_wr_addr_i(cfg_wr_addr),
    .cfg_wr_data_i(cfg_wr_data), .rst_req_i(rst_req), .nmi_n_i(nmi_n), .pa_n_i(pa_n),
    .pbc_i(pbc), .tmz_i(tmz), .eoc_i(eoc), .irq_valid_o(irq_valid), .irq_ready_i(irq_ready),
    .irq_vector_o(irq_vector), .irq_grant_o(irq_grant), .wake_o(wake)
  );

  always #(CLK_PERIOD_NS/2) clk = ~clk;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;
  bit m_gen, m_les, m_esb, m_nmi_p, m_pa_p, m_pbc_p;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit pa_model();
    return m_les ? !pa_n : m_pa_p;
  endfunction

  function automatic logic [11:0] exp_vec();
    if (rst_req)              return 12'hFFE;
    if (m_nmi_p)              return 12'hFFC;
    if (m_gen && pa_model())  return 12'hFF8;
    if (m_gen && m_pbc_p)     return 12'hFF6;
    if (m_gen && tmz)         return 12'hFF4;
    if (m_gen && eoc)         return 12'hFF2;
    return 12'h000;
  endfunction

  function automatic logic exp_wake();
    return rst_req || (m_gen && (m_nmi_p || pa_model() || m_pbc_p || tmz));
  endfunction

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(string tag);
    check({tag, " R3 vector"}, irq_vector, exp_vec());
    check({tag, " R11 valid"}, irq_valid, exp_vec() != 12'h000);
    check({tag, " R9 wake"}, wake, exp_wake());
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; rst_req = 0; nmi_n = 1; pa_n = 1; pbc = 1; eoc = 0; irq_ready = 0;
    m_gen = 0; m_les = 0; m_esb = 0; m_nmi_p = 0; m_pa_p = 0; m_pbc_p = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    settle(1);
  endtask

  task automatic write_cfg(logic [7:0] addr, logic [7:0] data);
    if (addr == 8'hC8 && (data & 8'h8F) == 8'h00) begin
      m_les = data[6]; m_esb = data[5]; m_gen = data[4];
      if (m_les) m_pa_p = 0;
    end
    @(negedge clk);
    cfg_wr_en = 1; cfg_wr_addr = addr; cfg_wr_data = data;
    @(negedge clk);
    cfg_wr_en = 0;
    settle(2);
  endtask

  task automatic drive_pins(logic n_v, logic a_v, logic b_v, logic t_v, logic e_v, logic r_v);
    if (nmi_n && !n_v) m_nmi_p = 1;
    if (!m_les && pa_n && !a_v) m_pa_p = 1;
    if (m_esb ? (!pbc && b_v) : (pbc && !b_v)) m_pbc_p = 1;
    @(negedge clk);
    nmi_n = n_v; pa_n = a_v; pbc = b_v; tmz = t_v; eoc = e_v; rst_req = r_v;
    settle(4);
  endtask

  task automatic accept_one();
    logic [11:0] w;
    w = exp_vec();
    if (w == 12'hFFC) m_nmi_p = 0;
    if (w == 12'hFF8 && !m_les) m_pa_p = 0;
    if (w == 12'hFF6) m_pbc_p = 0;
    @(negedge clk);
    irq_ready = 1;
    @(negedge clk);
    irq_ready = 0;
    settle(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errs++;
      $display("FAIL R11 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    tmz = 1;
    apply_reset();
    // R1: enable clear after reset, timer flag masked
    check("R1 valid", irq_valid, 0);
    check("R1 wake", wake, 0);
    check("R1 vector", irq_vector, 12'h000);

    // R2: wrong address ignored, right address takes effect
    write_cfg(8'hC9, 8'h10);
    check("R2 other address valid", irq_valid, 0);
    // R12: reserved bit set rejects the whole write
    write_cfg(8'hC8, 8'h11);
    check("R12 reserved write valid", irq_valid, 0);
    write_cfg(8'hC8, 8'h10);
    check("R2 enable vector", irq_vector, 12'hFF4);
    check("R9 timer wake", wake, 1);

    // R8: conversion level, no wake, not cleared by transfer
    drive_pins(1, 1, 1, 0, 1, 0);
    check("R8 adc vector", irq_vector, 12'hFF2);
    check("R9 adc no wake", wake, 0);
    accept_one();
    check("R8 adc after accept", irq_vector, 12'hFF2);
    drive_pins(1, 1, 1, 0, 0, 0);
    check("R8 adc dropped", irq_valid, 0);

    // R4 R5: NMI with enable clear, no wake
    write_cfg(8'hC8, 8'h00);
    drive_pins(0, 1, 1, 1, 0, 0);
    check("R4 nmi unmasked vector", irq_vector, 12'hFFC);
    check("R9 nmi gen0 no wake", wake, 0);
    check("R11 grant nmi", irq_grant, 8'h02);
    accept_one();
    check("R5 nmi cleared", irq_valid, 0);
    drive_pins(1, 1, 1, 0, 0, 0);

    // R3: all at once, then peel off in order
    write_cfg(8'hC8, 8'h10);
    drive_pins(0, 0, 0, 1, 1, 0);
    check("R3 first", irq_vector, 12'hFFC);
    check("R9 nmi wake", wake, 1);
    accept_one();
    check("R3 second", irq_vector, 12'hFF8);
    accept_one();
    check("R3 third", irq_vector, 12'hFF6);
    accept_one();
    check("R3 fourth", irq_vector, 12'hFF4);
    drive_pins(1, 1, 1, 0, 1, 1);
    check("R3 reset wins", irq_vector, 12'hFFE);
    check("R11 grant reset", irq_grant, 8'h01);
    drive_pins(1, 1, 1, 0, 1, 0);
    check("R3 fifth", irq_vector, 12'hFF2);
    drive_pins(1, 1, 1, 0, 0, 0);
    check("R3 none", irq_vector, 12'h000);

    // R6: low-level mode follows pin
    write_cfg(8'hC8, 8'h50);
    drive_pins(1, 0, 1, 0, 0, 0);
    check("R6 level vector", irq_vector, 12'hFF8);
    accept_one();
    check("R6 level after accept", irq_vector, 12'hFF8);
    drive_pins(1, 1, 1, 0, 0, 0);
    check("R6 level released", irq_valid, 0);
    write_cfg(8'hC8, 8'h10);
    drive_pins(1, 0, 1, 0, 0, 0);
    drive_pins(1, 1, 1, 0, 0, 0);
    check("R6 edge latched", irq_vector, 12'hFF8);
    accept_one();
    check("R6 edge cleared", irq_valid, 0);

    // R7: rising mode ignores falling edge
    write_cfg(8'hC8, 8'h30);
    drive_pins(1, 1, 0, 0, 0, 0);
    check("R7 falling ignored", irq_valid, 0);
    drive_pins(1, 1, 1, 0, 0, 0);
    check("R7 rising latched", irq_vector, 12'hFF6);
    accept_one();
    check("R7 cleared", irq_valid, 0);

    // R10: transfer and new edge in the same cycle
    write_cfg(8'hC8, 8'h10);
    drive_pins(1, 1, 0, 0, 0, 0);
    drive_pins(1, 1, 1, 0, 0, 0);
    check("R10 pending before", irq_vector, 12'hFF6);
    @(negedge clk);
    pbc = 0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    irq_ready = 1;
    @(negedge clk);
    irq_ready = 0;
    settle(1);
    check("R10 kept by new edge", irq_vector, 12'hFF6);
    accept_one();
    check("R10 later cleared", irq_valid, 0);

    // random mix checked against the model
    apply_reset();
    for (int k = 0; k < 300; k++) begin
      int r;
      r = $urandom % 10;
      if (r < 5) begin
        drive_pins(($urandom % 3) != 0, ($urandom % 3) != 0, 1'($urandom),
                   1'($urandom), 1'($urandom), ($urandom % 8) == 0);
      end else if (r < 8) begin
        accept_one();
      end else begin
        logic [7:0] a, d;
        a = (($urandom % 4) == 0) ? 8'($urandom) : 8'hC8;
        d = 8'($urandom);
        if (($urandom % 4) != 0) d = d & 8'h70;
        write_cfg(a, d);
      end
      check_all("random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule